// File: doc/BRIEF.md
# ECC Read Error Logger

This block sits on the read return path of a memory controller, just after an ECC decoder. For every returned read, the decoder reports whether the word was clean, had a single flipped bit (and which bit), or had a multi-bit fault. The block delivers the read response one cycle later. A clean word is passed through unchanged. A single-bit error is repaired by inverting the reported bit. A multi-bit error gets no repair and is flagged as a bus error. The stored memory word is never rewritten: the block has no write path back to memory, so a corrected read repairs only the data in flight.

Each single-bit or multi-bit error records the failing address and an error-type bit in a two-slot log and raises an interrupt. If an error arrives while both slots are occupied, a sticky overflow flag is set and that error's address is dropped. Software reads the slots from the block's outputs, frees a slot by pulsing a clear with the slot's index, and clears the overflow flag with a separate strobe. A clear and a new error in the same cycle are ordered clear-first, so the new error can take the slot that was just freed.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset no log slot is valid, the overflow flag is 0, the interrupt is 0 and no response is valid.
- R2: A read with `rd_valid_i`=1 and both error inputs 0 produces `resp_valid_o`=1 on the next cycle with `resp_data_o` equal to the input word and `resp_err_o`=0, and the log is left unchanged.
- R3: A read with `rd_sbe_i`=1 and `rd_mbe_i`=0 returns on the next cycle the input word with bit `rd_bitpos_i` inverted and `resp_err_o`=0, and logs the address with type bit 0.
- R4: A read with `rd_mbe_i`=1 (regardless of `rd_sbe_i`) returns the input word unmodified with `resp_err_o`=1 and logs the address with type bit 1.
- R5: A logged error goes into the lowest-numbered free slot (slot 0 before slot 1); bit i of `log_vld_o`/`log_type_o` belongs to slot i, and the slot's address appears on `log_addr0_o` or `log_addr1_o`.
- R6: An error arriving while both slots are valid sets `ovf_o` and leaves both slots' valid bits, types and addresses unchanged.
- R7: `irq_o` is 1 exactly when at least one slot is valid or `ovf_o` is 1.
- R8: A cycle with `clr_en_i`=1 invalidates the slot selected by `clr_idx_i` on the next cycle; `clr_ovf_i`=1 clears `ovf_o` on the next cycle.
- R9: Clears are applied before a same-cycle error: an error coinciding with the clear of a full log's slot fills that slot without overflow, and an overflow coinciding with `clr_ovf_i` leaves `ovf_o` at 1.
- R10: With `rd_valid_i`=0 the error inputs are ignored: `resp_valid_o` is 0 next cycle and the log and overflow flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid_i | input | 1 | Read word from the decoder is present |
| rd_addr_i | input | AW | Address of the read |
| rd_data_i | input | DW | Raw word as read from memory |
| rd_bitpos_i | input | log2(DW) | Index of the flipped bit for a single-bit error |
| rd_sbe_i | input | 1 | Decoder reports a correctable single-bit error |
| rd_mbe_i | input | 1 | Decoder reports an uncorrectable multi-bit error |
| clr_en_i | input | 1 | Free the log slot selected by clr_idx_i |
| clr_idx_i | input | 1 | Slot index to free |
| clr_ovf_i | input | 1 | Clear the overflow flag |
| resp_valid_o | output | 1 | Read response valid |
| resp_data_o | output | DW | Delivered (possibly corrected) word |
| resp_err_o | output | 1 | Bus error response for an uncorrectable read |
| log_vld_o | output | 2 | Per-slot valid bits |
| log_type_o | output | 2 | Per-slot type bit (0 corrected, 1 uncorrectable) |
| log_addr0_o | output | AW | Address held in slot 0 |
| log_addr1_o | output | AW | Address held in slot 1 |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The read path is driven with a clean word, a single-bit error at a chosen position, and a word where both error inputs are high, which separates pass-through, in-flight repair and the multi-bit priority with its bus error. Logging is exercised by filling slot 0 then slot 1, sending a third error to force overflow, and freeing slot 0 while slot 1 stays held to show that allocation picks the lowest free slot rather than the next in turn. Clears coinciding with a new error, and an overflow coinciding with the overflow clear, distinguish clear-first ordering from error-first ordering, while error inputs pulsed without a read valid show they are ignored.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    localparam int unsigned SLOTS = 2;

    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_CORR   = 2'd1,
        CLS_UNCORR = 2'd2
    } ecc_cls_e;

    // Multi-bit status dominates single-bit status.
    function automatic ecc_cls_e classify(input logic sbe, input logic mbe);
        if (mbe)
            return CLS_UNCORR;
        else if (sbe)
            return CLS_CORR;
        else
            return CLS_CLEAN;
    endfunction

endpackage

// File: rtl/ecc_fix_stage.sv
module ecc_fix_stage
    import ecc_log_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    localparam int unsigned PW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [DW-1:0] rd_data_i,
    input  logic [PW-1:0] rd_bitpos_i,
    input  logic          rd_sbe_i,
    input  logic          rd_mbe_i,
    output logic          resp_valid_o,
    output logic [DW-1:0] resp_data_o,
    output logic          resp_err_o,
    output logic          evt_vld_o,
    output logic          evt_uncorr_o,
    output logic [AW-1:0] evt_addr_o
);

    typedef struct packed {
        logic          vld;
        logic          berr;
        logic [DW-1:0] data;
    } resp_t;

    resp_t         r_d, r_q;
    ecc_cls_e      cls;
    logic [DW-1:0] flip;

    always_comb begin
        cls  = classify(rd_sbe_i, rd_mbe_i);
        flip = '0;
        if (cls == CLS_CORR)
            flip[rd_bitpos_i] = 1'b1;

        r_d      = r_q;
        r_d.vld  = rd_valid_i;
        r_d.berr = rd_valid_i && (cls == CLS_UNCORR);
        if (rd_valid_i)
            r_d.data = rd_data_i ^ flip;

        evt_vld_o    = rd_valid_i && (cls != CLS_CLEAN);
        evt_uncorr_o = (cls == CLS_UNCORR);
        evt_addr_o   = rd_addr_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign resp_valid_o = r_q.vld;
    assign resp_data_o  = r_q.data;
    assign resp_err_o   = r_q.berr;

    // R4: a bus error only follows a valid read flagged multi-bit
    p_berr_only_mbe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err_o |-> $past(rd_valid_i && rd_mbe_i));

    // R2: clean read passes the word unchanged
    p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_valid_i && !rd_sbe_i && !rd_mbe_i) |->
            (resp_data_o == $past(rd_data_i)) && !resp_err_o);

    // R3: a corrected read differs from the raw word in exactly one bit
    p_one_bit_fix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_valid_i && rd_sbe_i && !rd_mbe_i) |->
            ($countones(resp_data_o ^ $past(rd_data_i)) == 1));

    // R10: no response without a read
    p_no_resp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rd_valid_i) |-> !resp_valid_o);

endmodule

// File: rtl/ecc_err_slots.sv
module ecc_err_slots
    import ecc_log_pkg::*;
#(
    parameter int unsigned AW = 32,
    localparam int unsigned IW = $clog2(SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      evt_vld_i,
    input  logic                      evt_uncorr_i,
    input  logic [AW-1:0]             evt_addr_i,
    input  logic                      clr_en_i,
    input  logic [IW-1:0]             clr_idx_i,
    input  logic                      clr_ovf_i,
    output logic [SLOTS-1:0]          vld_o,
    output logic [SLOTS-1:0]          typ_o,
    output logic [SLOTS-1:0][AW-1:0]  addr_o,
    output logic                      ovf_o
);

    typedef struct packed {
        logic                     ovf;
        logic [SLOTS-1:0]         vld;
        logic [SLOTS-1:0]         typ;
        logic [SLOTS-1:0][AW-1:0] addr;
    } log_t;

    log_t l_d, l_q;
    logic placed;

    always_comb begin
        l_d    = l_q;
        placed = 1'b0;
        // Clears first, so a same-cycle error sees the freed slot.
        if (clr_en_i)
            l_d.vld[clr_idx_i] = 1'b0;
        if (clr_ovf_i)
            l_d.ovf = 1'b0;
        if (evt_vld_i) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (!placed && !l_d.vld[i]) begin
                    l_d.vld[i]  = 1'b1;
                    l_d.typ[i]  = evt_uncorr_i;
                    l_d.addr[i] = evt_addr_i;
                    placed      = 1'b1;
                end
            end
            if (!placed)
                l_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            l_q <= '0;
        else
            l_q <= l_d;
    end

    assign vld_o  = l_q.vld;
    assign typ_o  = l_q.typ;
    assign addr_o = l_q.addr;
    assign ovf_o  = l_q.ovf;

    // R6: overflow only rises with a full log that keeps its contents
    p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (vld_o == '1) && $stable(addr_o) && $stable(typ_o));

    // R8: a clear without a competing error frees the chosen slot
    p_clear_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !evt_vld_i) |=> !vld_o[$past(clr_idx_i)]);

    // R5: an error into an empty log lands in slot 0
    p_lowest_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld_i && !clr_en_i && vld_o == '0) |=>
            (vld_o[0] && addr_o[0] == $past(evt_addr_i)));

    // R10: without an error or a clear the log holds
    p_log_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_vld_i && !clr_en_i && !clr_ovf_i) |=>
            $stable(vld_o) && $stable(ovf_o));

endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
    import ecc_log_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 64,
    localparam int unsigned PW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [DW-1:0] rd_data_i,
    input  logic [PW-1:0] rd_bitpos_i,
    input  logic          rd_sbe_i,
    input  logic          rd_mbe_i,
    input  logic          clr_en_i,
    input  logic          clr_idx_i,
    input  logic          clr_ovf_i,
    output logic          resp_valid_o,
    output logic [DW-1:0] resp_data_o,
    output logic          resp_err_o,
    output logic [1:0]    log_vld_o,
    output logic [1:0]    log_type_o,
    output logic [AW-1:0] log_addr0_o,
    output logic [AW-1:0] log_addr1_o,
    output logic          ovf_o,
    output logic          irq_o
);

    logic                     evt_vld, evt_uncorr;
    logic [AW-1:0]            evt_addr;
    logic [SLOTS-1:0][AW-1:0] slot_addr;

    ecc_fix_stage #(.AW(AW), .DW(DW)) u_fix (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_valid_i   (rd_valid_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_i    (rd_data_i),
        .rd_bitpos_i  (rd_bitpos_i),
        .rd_sbe_i     (rd_sbe_i),
        .rd_mbe_i     (rd_mbe_i),
        .resp_valid_o (resp_valid_o),
        .resp_data_o  (resp_data_o),
        .resp_err_o   (resp_err_o),
        .evt_vld_o    (evt_vld),
        .evt_uncorr_o (evt_uncorr),
        .evt_addr_o   (evt_addr)
    );

    ecc_err_slots #(.AW(AW)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_vld_i    (evt_vld),
        .evt_uncorr_i (evt_uncorr),
        .evt_addr_i   (evt_addr),
        .clr_en_i     (clr_en_i),
        .clr_idx_i    (clr_idx_i),
        .clr_ovf_i    (clr_ovf_i),
        .vld_o        (log_vld_o),
        .typ_o        (log_type_o),
        .addr_o       (slot_addr),
        .ovf_o        (ovf_o)
    );

    assign log_addr0_o = slot_addr[0];
    assign log_addr1_o = slot_addr[1];
    assign irq_o       = ovf_o || (|log_vld_o);

    // R7: any logged or dropped error leaves the interrupt raised
    p_irq_after_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_vld) |-> irq_o);

    // R1: state right after reset is empty
    p_reset_empty_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (log_vld_o == 2'b00) && !ovf_o && !resp_valid_o);

endmodule

// File: tb/ecc_err_logger_test.sv
module ecc_err_logger_test;

    localparam int unsigned AW = 32;
    localparam int unsigned DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_valid_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [DW-1:0] rd_data_i = '0;
    logic [5:0]    rd_bitpos_i = '0;
    logic          rd_sbe_i = 1'b0;
    logic          rd_mbe_i = 1'b0;
    logic          clr_en_i = 1'b0;
    logic          clr_idx_i = 1'b0;
    logic          clr_ovf_i = 1'b0;
    logic          resp_valid_o, resp_err_o, ovf_o, irq_o;
    logic [DW-1:0] resp_data_o;
    logic [1:0]    log_vld_o, log_type_o;
    logic [AW-1:0] log_addr0_o, log_addr1_o;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    ecc_err_logger #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_data_i(rd_data_i),
        .rd_bitpos_i(rd_bitpos_i), .rd_sbe_i(rd_sbe_i), .rd_mbe_i(rd_mbe_i),
        .clr_en_i(clr_en_i), .clr_idx_i(clr_idx_i), .clr_ovf_i(clr_ovf_i),
        .resp_valid_o(resp_valid_o), .resp_data_o(resp_data_o), .resp_err_o(resp_err_o),
        .log_vld_o(log_vld_o), .log_type_o(log_type_o),
        .log_addr0_o(log_addr0_o), .log_addr1_o(log_addr1_o),
        .ovf_o(ovf_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; outputs are sampled 1 ns after the edge.
    task automatic step(input bit rv, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [5:0] pos, input bit sbe, input bit mbe,
                        input bit ce, input bit ci, input bit co);
        @(negedge clk);
        rd_valid_i = rv; rd_addr_i = a; rd_data_i = d; rd_bitpos_i = pos;
        rd_sbe_i = sbe; rd_mbe_i = mbe;
        clr_en_i = ce; clr_idx_i = ci; clr_ovf_i = co;
        @(posedge clk);
        #1;
        rd_valid_i = 1'b0; rd_sbe_i = 1'b0; rd_mbe_i = 1'b0;
        clr_en_i = 1'b0; clr_ovf_i = 1'b0;
    endtask

    task automatic clear_all();
        step(0, '0, '0, 0, 0, 0, 1, 0, 1);
        step(0, '0, '0, 0, 0, 0, 1, 1, 0);
    endtask

    task automatic t_reset();
        chk(log_vld_o == 2'b00, "R1 log valid after reset", 64'(log_vld_o), 0);
        chk(!ovf_o && !irq_o, "R1 ovf/irq after reset", {ovf_o, irq_o}, 0);
        chk(!resp_valid_o, "R1 resp valid after reset", 64'(resp_valid_o), 0);
    endtask

    task automatic t_clean();
        logic [DW-1:0] d = 64'hDEAD_BEEF_0123_4567;
        step(1, 32'h1000, d, 6'd9, 0, 0, 0, 0, 0);
        chk(resp_valid_o && !resp_err_o, "R2 clean resp valid/err", {resp_valid_o, resp_err_o}, 2'b10);
        chk(resp_data_o == d, "R2 clean data", resp_data_o, d);
        chk(log_vld_o == 2'b00 && !irq_o, "R2 clean no log", {log_vld_o, irq_o}, 0);
        step(0, 32'h2000, d, 6'd3, 1, 1, 0, 0, 0);
        chk(!resp_valid_o, "R10 idle no resp", 64'(resp_valid_o), 0);
        chk(log_vld_o == 2'b00 && !ovf_o, "R10 idle no log", {log_vld_o, ovf_o}, 0);
    endtask

    task automatic t_single_multi();
        logic [DW-1:0] d = 64'h0F0F_0000_AAAA_5555;
        logic [DW-1:0] e = d ^ (64'd1 << 37);
        step(1, 32'h0000_A100, d, 6'd37, 1, 0, 0, 0, 0);
        chk(resp_data_o == e, "R3 corrected data", resp_data_o, e);
        chk(!resp_err_o, "R3 no bus error", 64'(resp_err_o), 0);
        chk(log_vld_o == 2'b01 && log_type_o[0] == 1'b0, "R3 slot0 type corr",
            {log_vld_o, log_type_o}, 4'b0100);
        chk(log_addr0_o == 32'h0000_A100, "R5 slot0 addr", log_addr0_o, 32'h0000_A100);
        chk(irq_o, "R7 irq with valid slot", 64'(irq_o), 1);
        step(1, 32'h0000_B200, d, 6'd2, 1, 1, 0, 0, 0);
        chk(resp_data_o == d && resp_err_o, "R4 uncorrectable raw + err", resp_data_o, d);
        chk(log_vld_o == 2'b11 && log_type_o[1] == 1'b1, "R4 slot1 type uncorr",
            {log_vld_o, log_type_o}, 4'b1110);
        chk(log_addr1_o == 32'h0000_B200, "R5 slot1 addr", log_addr1_o, 32'h0000_B200);
    endtask

    task automatic t_overflow();
        step(1, 32'h0000_C300, 64'h1, 6'd0, 1, 0, 0, 0, 0);
        chk(ovf_o, "R6 ovf set", 64'(ovf_o), 1);
        chk(resp_data_o == 64'h0, "R3 still corrected on overflow", resp_data_o, 0);
        chk(log_vld_o == 2'b11 && log_addr0_o == 32'h0000_A100 && log_addr1_o == 32'h0000_B200,
            "R6 log unchanged", {log_addr0_o, log_addr1_o}, {32'h0000_A100, 32'h0000_B200});
        chk(log_type_o == 2'b10, "R6 types unchanged", 64'(log_type_o), 2'b10);
    endtask

    task automatic t_clear();
        step(0, '0, '0, 0, 0, 0, 1, 0, 0);
        chk(log_vld_o == 2'b10, "R8 slot0 freed", 64'(log_vld_o), 2'b10);
        chk(irq_o && ovf_o, "R7 irq held", {irq_o, ovf_o}, 2'b11);
        step(0, '0, '0, 0, 0, 0, 0, 0, 1);
        chk(!ovf_o, "R8 ovf cleared", 64'(ovf_o), 0);
        step(1, 32'h0000_D400, 64'h0, 6'd1, 0, 1, 0, 0, 0);
        chk(log_vld_o == 2'b11 && log_addr0_o == 32'h0000_D400, "R5 lowest free slot",
            log_addr0_o, 32'h0000_D400);
        chk(log_addr1_o == 32'h0000_B200, "R5 slot1 kept", log_addr1_o, 32'h0000_B200);
        clear_all();
        chk(log_vld_o == 2'b00 && !ovf_o && !irq_o, "R7 irq low when empty",
            {log_vld_o, ovf_o, irq_o}, 0);
    endtask

    task automatic t_coincide();
        step(1, 32'h0000_1111, 64'h0, 6'd0, 1, 0, 0, 0, 0);
        step(1, 32'h0000_2222, 64'h0, 6'd0, 1, 0, 0, 0, 0);
        step(1, 32'h0000_3333, 64'h0, 6'd0, 0, 1, 1, 1, 0);
        chk(log_vld_o == 2'b11 && !ovf_o, "R9 error takes freed slot", {log_vld_o, ovf_o}, 3'b110);
        chk(log_addr1_o == 32'h0000_3333 && log_type_o[1], "R9 slot1 new addr",
            log_addr1_o, 32'h0000_3333);
        step(1, 32'h0000_4444, 64'h0, 6'd0, 1, 0, 0, 0, 1);
        chk(ovf_o, "R9 ovf set despite same-cycle clear", 64'(ovf_o), 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                #1;
                t_reset();
                @(negedge clk);
                rst_n = 1'b1;
                t_clean();
                t_single_multi();
                t_overflow();
                t_clear();
                t_coincide();
            end
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule